// File: doc/BRIEF.md
# Flash Program/Erase Sequencer

This block sits on the host side of a byte-wide flash bus and runs the device's command protocols without software help. A client hands it one request at a time through a valid/ready handshake. A request either programs one byte at a given address, or erases a set of sectors given as a bit mask. The sequencer issues the unlock and command write cycles. It then reads the device status over and over until the embedded operation reports completion, and returns a result code on a one-cycle response strobe.

Completion is detected by data polling on bit 7 by default, or by watching bit 6 stop toggling when the request selects toggle mode. A raised time-limit bit (bit 5) never causes a failure on the read that shows it. The sequencer reads once more first, because bit 7 and bit 5 may change in the same read. A device failure or an expired clock-cycle watchdog leads to the reset command sequence before the response is given. After an erase, a final read must return FFh.

The flash bus is a synchronous strobe interface. `fl_we` writes `fl_addr`/`fl_wdata` in the cycle it is high. `fl_re` requests a read of `fl_addr`, and the byte comes back on `fl_rdata` in the following cycle.

Top module: `fsq_flash_seq`

## Requirements
- R1: A program request produces exactly four writes in this order: 5555h/AAh, 2AAAh/55h, 5555h/A0h, then the request address with the request data.
- R2: An erase request with mask bits set produces six writes: 5555h/AAh, 2AAAh/55h, 5555h/80h, 5555h/AAh, 2AAAh/55h, and finally the base of the lowest selected sector with 30h. One extra write of 30h to each further selected sector base follows, in ascending sector order. The base of sector k is k placed in the top SECT_W address bits with all lower bits zero.
- R3: Every status and verify read targets the programmed address for a program, or the base of the lowest selected sector for an erase.
- R4: In data-polling mode the operation completes when read bit 7 equals the expected bit 7. The expected bit is bit 7 of the programmed data, or 1 for an erase. A program then responds with code 0 (OK).
- R5: When a non-completing status read shows bit 5 = 1, exactly one further read is made. The result is code 0 if that read completes, and code 1 (device failure) otherwise.
- R6: After a code 1 or code 3 outcome, the three writes 5555h/AAh, 2AAAh/55h, 5555h/F0h are issued before the response.
- R7: In toggle mode (`req_toggle`=1) the operation completes when two consecutive status reads show the same bit 6. The bit-5 recheck of R5 applies in the same way.
- R8: After each extra sector write, one status read is made. If its bit 3 is 1, `rsp_rejected` is 1 in the response.
- R9: After an erase completes, one more read is made. If it is not FFh, the response code is 2 (verify error), otherwise 0.
- R10: If polling has not completed within WDOG_CYC clock cycles, the sequencer aborts with code 3 (watchdog).
- R11: An erase request with an all-zero mask responds with code 4 (bad request) and makes no bus cycle.
- R12: After reset and whenever idle, `req_ready` is 1 and no bus strobe is active. `fl_we` and `fl_re` are never high together. `rsp_valid` is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle; request taken when both high |
| req_erase | input | 1 | 1 = sector erase, 0 = byte program |
| req_toggle | input | 1 | 1 = detect completion by bit-6 toggle |
| req_addr | input | ADDR_W | Byte address for a program |
| req_data | input | 8 | Byte to program |
| req_smask | input | 2**SECT_W | Sectors to erase, bit k = sector k |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_code | output | 3 | 0 OK, 1 device failure, 2 verify error, 3 watchdog, 4 bad request |
| rsp_rejected | output | 1 | An extra sector command saw bit 3 already high |
| fl_we | output | 1 | Flash write strobe |
| fl_re | output | 1 | Flash read strobe |
| fl_addr | output | ADDR_W | Flash address |
| fl_wdata | output | 8 | Flash write data |
| fl_rdata | input | 8 | Flash read data, valid the cycle after `fl_re` |

## Verification
The checks assume that `fl_rdata` is only consulted one cycle after a read strobe. They also assume that a request is only offered while `req_ready` is high, so the latched polling address cannot change during an operation. The bench keeps to this: its flash model registers read data at the strobe edge, and it raises `req_valid` only between responses. The bench drives status bytes from a scripted busy count, a bit-5 onset index and a bit-3 value. These sit in the same bits a real device uses, so every polling branch is reached with status values that obey the protocol.

// File: rtl/fsq_pkg.sv
package fsq_pkg;
  localparam logic [15:0] UNLK_A1   = 16'h5555;
  localparam logic [15:0] UNLK_A2   = 16'h2AAA;
  localparam logic [7:0]  UNLK_D1   = 8'hAA;
  localparam logic [7:0]  UNLK_D2   = 8'h55;
  localparam logic [7:0]  OPC_PROG  = 8'hA0;
  localparam logic [7:0]  OPC_ERASE = 8'h80;
  localparam logic [7:0]  OPC_RESET = 8'hF0;
  localparam logic [7:0]  OPC_SECT  = 8'h30;

  typedef enum logic [1:0] {SEQ_PROG, SEQ_ERASE, SEQ_RESET} seq_e;
  typedef enum logic [1:0] {V_WAIT, V_PASS, V_RETRY, V_FAIL} verdict_e;
  typedef enum logic [2:0] {
    RC_OK = 3'd0, RC_DEVFAIL = 3'd1, RC_VERIFY = 3'd2, RC_WDOG = 3'd3, RC_BADREQ = 3'd4
  } rcode_e;

  // index of the final write of each command sequence
  function automatic logic [2:0] seq_last(input seq_e k);
    case (k)
      SEQ_PROG:  return 3'd3;
      SEQ_ERASE: return 3'd5;
      default:   return 3'd2;
    endcase
  endfunction

  // third byte of a sequence selects the operation
  function automatic logic [7:0] setup_byte(input seq_e k);
    case (k)
      SEQ_PROG:  return OPC_PROG;
      SEQ_ERASE: return OPC_ERASE;
      default:   return OPC_RESET;
    endcase
  endfunction
endpackage

// File: rtl/fsq_cmd_gen.sv
module fsq_cmd_gen
  import fsq_pkg::*;
#(
  parameter int ADDR_W = 17
) (
  input  seq_e              kind,
  input  logic [2:0]        step,
  input  logic [ADDR_W-1:0] tgt_addr,
  input  logic [7:0]        tgt_data,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data,
  output logic              last
);
  localparam logic [ADDR_W-1:0] A1 = ADDR_W'(UNLK_A1);
  localparam logic [ADDR_W-1:0] A2 = ADDR_W'(UNLK_A2);

  always_comb begin
    last    = (step == seq_last(kind));
    wr_addr = A1;
    wr_data = UNLK_D1;
    case (step)
      3'd1, 3'd4: begin
        wr_addr = A2;
        wr_data = UNLK_D2;
      end
      3'd2: wr_data = setup_byte(kind);
      3'd3: if (kind == SEQ_PROG) begin
        wr_addr = tgt_addr;
        wr_data = tgt_data;
      end
      3'd5: begin
        wr_addr = tgt_addr;
        wr_data = OPC_SECT;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/fsq_poll_eval.sv
module fsq_poll_eval
  import fsq_pkg::*;
(
  input  logic     d7,
  input  logic     d6,
  input  logic     d5,
  input  logic     exp7,
  input  logic     tog_mode,
  input  logic     prev6,
  input  logic     prev_ok,
  input  logic     retry_pend,
  output verdict_e verdict
);
  logic done_now;

  always_comb begin
    if (tog_mode) done_now = prev_ok && (d6 == prev6);
    else          done_now = (d7 == exp7);
    if (done_now)                        verdict = V_PASS;
    else if (retry_pend)                 verdict = V_FAIL;
    else if (d5 && (!tog_mode || prev_ok)) verdict = V_RETRY;
    else                                 verdict = V_WAIT;
  end
endmodule

// File: rtl/fsq_wdog.sv
module fsq_wdog #(
  parameter int LIM = 4096
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expired
);
  localparam int CW = $clog2(LIM + 1);
  logic [CW-1:0] cnt;

  assign expired = (cnt == CW'(LIM));

  always_ff @(posedge clk) begin
    if (!rst_n)        cnt <= '0;
    else if (!run)     cnt <= '0;
    else if (!expired) cnt <= cnt + CW'(1);
  end
endmodule

// File: rtl/fsq_flash_seq.sv
module fsq_flash_seq
  import fsq_pkg::*;
#(
  parameter int ADDR_W   = 17,
  parameter int SECT_W   = 3,
  parameter int WDOG_CYC = 4096
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic                     req_erase,
  input  logic                     req_toggle,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic [7:0]               req_data,
  input  logic [(1<<SECT_W)-1:0]   req_smask,
  output logic                     rsp_valid,
  output logic [2:0]               rsp_code,
  output logic                     rsp_rejected,
  output logic                     fl_we,
  output logic                     fl_re,
  output logic [ADDR_W-1:0]        fl_addr,
  output logic [7:0]               fl_wdata,
  input  logic [7:0]               fl_rdata
);
  localparam int NSECT = 1 << SECT_W;
  localparam int LOW_W = ADDR_W - SECT_W;

  typedef enum logic [3:0] {
    S_IDLE, S_CMD, S_XWR, S_XRD, S_XCHK, S_PRD, S_PCHK, S_VRD, S_VCHK, S_DONE
  } st_e;

  function automatic logic [SECT_W-1:0] low_idx(input logic [NSECT-1:0] m);
    logic [SECT_W-1:0] r;
    r = '0;
    for (int i = NSECT - 1; i >= 0; i--) if (m[i]) r = SECT_W'(i);
    return r;
  endfunction

  function automatic logic [ADDR_W-1:0] sect_base(input logic [SECT_W-1:0] s);
    return {s, {LOW_W{1'b0}}};
  endfunction

  function automatic logic [NSECT-1:0] sect_bit(input logic [SECT_W-1:0] s);
    return NSECT'(1) << s;
  endfunction

  st_e               st;
  seq_e              kind;
  logic [2:0]        step;
  logic              is_erase, tmode;
  logic [ADDR_W-1:0] tgt_addr, poll_addr;
  logic [7:0]        tgt_data;
  logic [NSECT-1:0]  rem;
  logic              exp7, prev6, prev_ok, retry_pend, rej;
  rcode_e            rc;

  logic [ADDR_W-1:0] cg_addr;
  logic [7:0]        cg_data;
  logic              cg_last;
  verdict_e          verdict;
  logic              wd_exp;
  logic [SECT_W-1:0] xsel;
  logic [SECT_W-1:0] req_low;

  // events brought out for the checker
  logic ev_fail, wd_hit;

  assign xsel    = low_idx(rem);
  assign req_low = low_idx(req_smask);
  assign ev_fail = (st == S_PCHK) && (verdict == V_FAIL);
  assign wd_hit  = (st == S_PRD) && wd_exp;

  fsq_cmd_gen #(.ADDR_W(ADDR_W)) u_cmd (
    .kind(kind), .step(step), .tgt_addr(tgt_addr), .tgt_data(tgt_data),
    .wr_addr(cg_addr), .wr_data(cg_data), .last(cg_last)
  );

  fsq_poll_eval u_eval (
    .d7(fl_rdata[7]), .d6(fl_rdata[6]), .d5(fl_rdata[5]), .exp7(exp7),
    .tog_mode(tmode), .prev6(prev6), .prev_ok(prev_ok),
    .retry_pend(retry_pend), .verdict(verdict)
  );

  fsq_wdog #(.LIM(WDOG_CYC)) u_wdog (
    .clk(clk), .rst_n(rst_n), .run((st == S_PRD) || (st == S_PCHK)), .expired(wd_exp)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;        kind <= SEQ_PROG;   step <= '0;
      is_erase <= 1'b0;    tmode <= 1'b0;      tgt_addr <= '0;
      tgt_data <= '0;      poll_addr <= '0;    rem <= '0;
      exp7 <= 1'b0;        prev6 <= 1'b0;      prev_ok <= 1'b0;
      retry_pend <= 1'b0;  rej <= 1'b0;        rc <= RC_OK;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          is_erase   <= req_erase;
          tmode      <= req_toggle;
          step       <= '0;
          prev_ok    <= 1'b0;
          retry_pend <= 1'b0;
          rej        <= 1'b0;
          rc         <= RC_OK;
          if (req_erase) begin
            if (req_smask == '0) begin
              rc <= RC_BADREQ;
              st <= S_DONE;
            end else begin
              kind      <= SEQ_ERASE;
              tgt_addr  <= sect_base(req_low);
              poll_addr <= sect_base(req_low);
              rem       <= req_smask & ~sect_bit(req_low);
              exp7      <= 1'b1;
              st        <= S_CMD;
            end
          end else begin
            kind      <= SEQ_PROG;
            tgt_addr  <= req_addr;
            tgt_data  <= req_data;
            poll_addr <= req_addr;
            exp7      <= req_data[7];
            st        <= S_CMD;
          end
        end
        S_CMD: begin
          if (cg_last) begin
            step <= '0;
            if (kind == SEQ_RESET)                     st <= S_DONE;
            else if (kind == SEQ_ERASE && rem != '0)   st <= S_XWR;
            else                                       st <= S_PRD;
          end else begin
            step <= step + 3'd1;
          end
        end
        S_XWR: begin
          rem <= rem & ~sect_bit(xsel);
          st  <= S_XRD;
        end
        S_XRD: st <= S_XCHK;
        S_XCHK: begin
          if (fl_rdata[3]) rej <= 1'b1;
          st <= (rem != '0) ? S_XWR : S_PRD;
        end
        S_PRD: begin
          if (wd_exp) begin
            rc   <= RC_WDOG;
            kind <= SEQ_RESET;
            step <= '0;
            st   <= S_CMD;
          end else begin
            st <= S_PCHK;
          end
        end
        S_PCHK: begin
          prev6   <= fl_rdata[6];
          prev_ok <= 1'b1;
          case (verdict)
            V_PASS:  st <= is_erase ? S_VRD : S_DONE;
            V_RETRY: begin
              retry_pend <= 1'b1;
              st         <= S_PRD;
            end
            V_FAIL: begin
              rc   <= RC_DEVFAIL;
              kind <= SEQ_RESET;
              step <= '0;
              st   <= S_CMD;
            end
            default: st <= S_PRD;
          endcase
        end
        S_VRD: st <= S_VCHK;
        S_VCHK: begin
          if (fl_rdata != 8'hFF) rc <= RC_VERIFY;
          st <= S_DONE;
        end
        S_DONE:  st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    req_ready    = (st == S_IDLE);
    rsp_valid    = (st == S_DONE);
    rsp_code     = rc;
    rsp_rejected = rej;
    fl_we        = (st == S_CMD) || (st == S_XWR);
    fl_re        = ((st == S_PRD) && !wd_exp) || (st == S_XRD) || (st == S_VRD);
    fl_addr      = '0;
    fl_wdata     = '0;
    case (st)
      S_CMD: begin
        fl_addr  = cg_addr;
        fl_wdata = cg_data;
      end
      S_XWR: begin
        fl_addr  = sect_base(xsel);
        fl_wdata = OPC_SECT;
      end
      S_PRD, S_XRD, S_VRD: fl_addr = poll_addr;
      default: ;
    endcase
  end
endmodule

// File: rtl/fsq_flash_seq_chk.sv
module fsq_flash_seq_chk #(
  parameter int ADDR_W = 17
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic [2:0]        rsp_code,
  input logic              fl_we,
  input logic              fl_re,
  input logic [ADDR_W-1:0] fl_addr,
  input logic [ADDR_W-1:0] poll_addr,
  input logic              ev_fail,
  input logic              retry_pend,
  input logic              wd_hit
);
  AST_BUS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(fl_we && fl_re)); // R12
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!fl_we && !fl_re)); // R12
  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R12
  AST_POLL_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && $past(!req_ready)) |-> $stable(poll_addr)); // R3
  AST_FAIL_AFTER_RECHECK: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fail |-> retry_pend); // R5
  AST_WDOG_RESET_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
    wd_hit |=> (fl_we && fl_addr == ADDR_W'(16'h5555))); // R10
  AST_BADREQ_NO_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_code == 3'd4) |-> $past(req_ready)); // R11
endmodule

bind fsq_flash_seq fsq_flash_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_valid(rsp_valid),
  .rsp_code(rsp_code), .fl_we(fl_we), .fl_re(fl_re), .fl_addr(fl_addr),
  .poll_addr(poll_addr), .ev_fail(ev_fail), .retry_pend(retry_pend), .wd_hit(wd_hit)
);

// File: tb/tb_fsq_flash_seq.sv
module tb_fsq_flash_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        req_valid = 1'b0, req_erase = 1'b0, req_toggle = 1'b0;
  logic [16:0] req_addr = '0;
  logic [7:0]  req_data = '0, req_smask = '0;
  logic        req_ready, rsp_valid, rsp_rejected, fl_we, fl_re;
  logic [2:0]  rsp_code;
  logic [16:0] fl_addr;
  logic [7:0]  fl_wdata;
  logic [7:0]  rd_q = '0;

  fsq_flash_seq #(.ADDR_W(17), .SECT_W(3), .WDOG_CYC(40)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_erase(req_erase), .req_toggle(req_toggle), .req_addr(req_addr),
    .req_data(req_data), .req_smask(req_smask), .rsp_valid(rsp_valid),
    .rsp_code(rsp_code), .rsp_rejected(rsp_rejected), .fl_we(fl_we),
    .fl_re(fl_re), .fl_addr(fl_addr), .fl_wdata(fl_wdata), .fl_rdata(rd_q)
  );

  int total = 0, bad = 0;

  // flash model knobs and expected write list (written by the stimulus only)
  int          m_busy = 0, m_t5 = -1;
  logic        m_d3 = 1'b0, m_exp7 = 1'b0;
  logic [7:0]  m_final = 8'hFF;
  logic [16:0] m_poll = '0;
  logic [16:0] ea [0:31];
  logic [7:0]  ed [0:31];
  int          ne = 0, nw0 = 0;

  // model state (written by the model only)
  int nw = 0, wr_bad = 0, rd_bad = 0, nrd = 0, ridx = 0;

  function automatic logic [7:0] status(input int i);
    logic b5;
    b5 = (m_t5 >= 0) && (i >= m_t5);
    if (i < m_busy) return {~m_exp7, i[0], b5, 1'b0, m_d3, 3'b000};
    return m_final;
  endfunction

  always @(posedge clk) begin
    int k;
    if (rst_n && fl_we) begin
      k = nw - nw0;
      if (k >= 32 || k >= ne) wr_bad <= wr_bad + 1;
      else if (fl_addr != ea[k] || fl_wdata != ed[k]) wr_bad <= wr_bad + 1;
      nw   <= nw + 1;
      ridx <= 0;
    end else if (rst_n && fl_re) begin
      if (fl_addr != m_poll) rd_bad <= rd_bad + 1;
      rd_q <= status(ridx);
      ridx <= ridx + 1;
      nrd  <= nrd + 1;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [16:0] sbase(input int k);
    return 17'(k << 14);
  endfunction

  task automatic push(input logic [16:0] a, input logic [7:0] d);
    ea[ne] = a;
    ed[ne] = d;
    ne++;
  endtask

  task automatic push_unlock(input logic [7:0] c);
    push(17'h05555, 8'hAA);
    push(17'h02AAA, 8'h55);
    push(17'h05555, c);
  endtask

  task automatic run_op(input bit er, input bit tog, input logic [16:0] a,
                        input logic [7:0] d, input logic [7:0] mask,
                        input int busy, input int t5, input bit d3,
                        input logic [7:0] fin, input int ecode, input bit erej,
                        input string req);
    int first, wb0, rb0, nr0;
    ne = 0;
    first = -1;
    if (!er) begin
      push_unlock(8'hA0);
      push(a, d);
      m_poll = a;
      m_exp7 = d[7];
    end else if (mask != 0) begin
      for (int k = 7; k >= 0; k--) if (mask[k]) first = k;
      push_unlock(8'h80);
      push(17'h05555, 8'hAA);
      push(17'h02AAA, 8'h55);
      push(sbase(first), 8'h30);
      for (int k = first + 1; k < 8; k++) if (mask[k]) push(sbase(k), 8'h30);
      m_poll = sbase(first);
      m_exp7 = 1'b1;
    end
    if (ecode == 1 || ecode == 3) push_unlock(8'hF0);
    m_busy = busy; m_t5 = t5; m_d3 = d3; m_final = fin;
    @(negedge clk);
    nw0 = nw; wb0 = wr_bad; rb0 = rd_bad; nr0 = nrd;
    req_valid = 1'b1; req_erase = er; req_toggle = tog;
    req_addr = a; req_data = d; req_smask = mask;
    @(negedge clk);
    req_valid = 1'b0;
    while (!rsp_valid) @(negedge clk);
    check(rsp_code == 3'(ecode), req, "response code", int'(rsp_code), ecode);
    check(rsp_rejected == erej, req, "rejected flag", int'(rsp_rejected), int'(erej));
    @(negedge clk);
    check(nw - nw0 == ne && wr_bad == wb0, req, "write sequence",
          nw - nw0 + 1000 * (wr_bad - wb0), ne);
    check(rd_bad == rb0, req, "read address", rd_bad - rb0, 0);
    if (er && mask == 0) check(nrd == nr0, "R11", "read count", nrd - nr0, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int wb;
    repeat (3) @(negedge clk);
    // R12 reset state
    check(req_ready == 1'b1, "R12", "ready after reset", int'(req_ready), 1);
    check(!fl_we && !fl_re, "R12", "strobes after reset", int'({fl_we, fl_re}), 0);
    check(rsp_valid == 1'b0, "R12", "response after reset", int'(rsp_valid), 0);
    rst_n = 1'b1;
    wb = nw;
    repeat (5) @(negedge clk);
    check(nw == wb && nrd == 0, "R12", "idle bus activity", nw - wb + nrd, 0);

    // R1 R3 R4: program sweep in data-polling mode
    for (int ai = 0; ai < 4; ai++) begin
      for (int di = 0; di < 6; di++) begin
        logic [16:0] av;
        logic [7:0]  dv;
        av = (ai == 0) ? 17'h00000 : (ai == 1) ? 17'h1FFFF : (ai == 2) ? 17'h05555 : 17'h12345;
        dv = (di == 0) ? 8'h00 : (di == 1) ? 8'h80 : (di == 2) ? 8'h7F :
             (di == 3) ? 8'hFF : (di == 4) ? 8'hA5 : 8'h3C;
        run_op(1'b0, 1'b0, av, dv, 8'h00, 1 + ai + di, -1, 1'b0, dv, 0, 1'b0, "R1_R3_R4");
      end
    end

    // R5: bit 5 and bit 7 resolve on the read after the flag
    run_op(1'b0, 1'b0, 17'h00ABC, 8'h5A, 8'h00, 5, 4, 1'b0, 8'h5A, 0, 1'b0, "R5_recheck_pass");
    // R5 R6: recheck still busy -> device failure and reset writes
    run_op(1'b0, 1'b0, 17'h00ABC, 8'hC3, 8'h00, 1 << 30, 3, 1'b0, 8'hC3, 1, 1'b0, "R5_R6_fail");
    // R7: toggle mode program, pass and fail
    run_op(1'b0, 1'b1, 17'h04000, 8'h81, 8'h00, 4, -1, 1'b0, 8'h81, 0, 1'b0, "R7_toggle_pass");
    run_op(1'b0, 1'b1, 17'h04000, 8'h81, 8'h00, 1 << 30, 2, 1'b0, 8'h81, 1, 1'b0, "R7_R6_toggle_fail");
    // R10 R6: device never finishes and never flags
    run_op(1'b0, 1'b0, 17'h1F000, 8'h11, 8'h00, 1 << 30, -1, 1'b0, 8'h11, 3, 1'b0, "R10_R6_wdog");

    // R2 R3 R4 R9: every non-empty sector mask
    for (int m = 1; m < 256; m++)
      run_op(1'b1, 1'b0, 17'h0, 8'h0, 8'(m), 6, -1, 1'b0, 8'hFF, 0, 1'b0, "R2_R4_erase");

    // R8: bit 3 already high on extra sector commands
    run_op(1'b1, 1'b0, 17'h0, 8'h0, 8'h01, 6, -1, 1'b1, 8'hFF, 0, 1'b0, "R8_single");
    run_op(1'b1, 1'b0, 17'h0, 8'h0, 8'h03, 6, -1, 1'b1, 8'hFF, 0, 1'b1, "R8_pair");
    run_op(1'b1, 1'b0, 17'h0, 8'h0, 8'h81, 6, -1, 1'b1, 8'hFF, 0, 1'b1, "R8_ends");
    // R9: erase finishes but one byte is not blank
    run_op(1'b1, 1'b0, 17'h0, 8'h0, 8'h10, 3, -1, 1'b0, 8'hEF, 2, 1'b0, "R9_verify");
    run_op(1'b1, 1'b0, 17'h0, 8'h0, 8'h10, 3, -1, 1'b0, 8'hFE, 2, 1'b0, "R9_verify_lsb");
    // R7: toggle mode erase
    run_op(1'b1, 1'b1, 17'h0, 8'h0, 8'h24, 5, -1, 1'b0, 8'hFF, 0, 1'b0, "R7_toggle_erase");
    // R11: empty mask
    run_op(1'b1, 1'b0, 17'h0, 8'h0, 8'h00, 3, -1, 1'b0, 8'hFF, 4, 1'b0, "R11_badreq");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule